// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This block takes two single-precision operands and returns either the smaller or the larger of them. Five selectable semantics set how NaNs and pairs of zeros are treated: IEEE minNum/maxNum, Java, the C macro form, C++ and Fortran. Each semantics can also run in a magnitude variant that compares absolute values. The block also reports an invalid-operation flag. It is one lane, wrapped in a single register stage: a request presented with `in_valid` produces its result, its flag and `out_valid` on the next clock edge.

The 4-bit `mode` field selects the behaviour. Bit 3 chooses the magnitude variant. Bits 2:0 give the base semantics. A NaN is silenced by setting fraction bit 22, its most significant fraction bit. Several rules return an operand's bits unchanged. Others return one of the operands with bit 22 forced to one.

Top module: `fp_minmax_sel`

## Requirements
- R1: `result`, `invalid` and `out_valid` are registered. A request sampled with `in_valid` high at a clock edge appears on them right after that edge. During reset, and after it until the first request, `out_valid` is 0.
- R2: `mode[3]` selects the magnitude variant. `mode[2:0]` selects the base semantics: 0 IEEE, 1 Java, 2 C macro, 3 C++, 4 Fortran. Base values 5, 6 and 7 behave exactly like 0.
- R3: For every non-IEEE base, when neither operand is a NaN and they are not both zero, a minimum returns the numerically smaller operand and a maximum returns the larger one. The returned bits are unchanged.
- R4: For the IEEE base, if either operand is a signaling NaN, the result is that NaN silenced, with A preferred, and invalid is raised. Otherwise, a single quiet NaN is discarded and the other operand is returned. If both operands are quiet NaNs, A is returned with bit 22 set.
- R5: For the IEEE base without magnitude, the numerically smaller or larger operand is returned. When both operands are zeros of different sign, a minimum returns -0 and a maximum returns +0.
- R6: For Java with a NaN present, these checks apply in order. A signaling NaN in A is returned silenced. Otherwise a signaling NaN in B is returned silenced. Otherwise A is returned if it is a NaN, and B if it is not.
- R7: For Fortran with a NaN present, A is returned if B is a NaN, and B is returned otherwise. No NaN is silenced.
- R8: For C macro with a NaN present, B is returned. For C++ with a NaN present, A is returned. In both cases invalid is raised.
- R9: For every base, invalid is raised whenever either operand is a signaling NaN. Outside R8, invalid stays 0 when no signaling NaN is present.
- R10: For a non-IEEE minimum of two zeros: Java and Fortran return A if A is negative and B otherwise. C macro returns B. C++ returns A.
- R11: For a non-IEEE maximum of two zeros: Java and Fortran return B if A is negative and A otherwise. C macro returns B. C++ returns A.
- R12: In the non-IEEE magnitude variants, both operands have their sign bit cleared before any selection. The result therefore always has bit 31 equal to 0.
- R13: In the IEEE magnitude variant, NaNs follow R4. Otherwise the operand with the smaller magnitude (for a minimum) or the larger magnitude (for a maximum) is returned with its sign kept. When the magnitudes are equal, the signed rule of R5 decides.
- R14: When `in_valid` is low at an edge, `out_valid` and `invalid` become 0 after that edge, and `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is presented this cycle |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| want_max | input | 1 | 1 selects maximum, 0 selects minimum |
| mode | input | 4 | Bit 3 selects magnitude; bits 2:0 select the base semantics |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| result | output | 32 | Selected value |
| invalid | output | 1 | Invalid-operation flag for that result |

## Verification
Each result and its invalid flag are due exactly one edge after the request. The bench applies one request at a falling edge and compares the outputs at the next falling edge, after the capturing rising edge. The next request is driven at that same falling edge, so the sweep runs one request per cycle with no slack in either direction. The idle check drops `in_valid` for one cycle and samples the held result after one edge.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

    // Operand classification produced per operand
    typedef struct packed {
        logic nan;
        logic snan;
        logic zero;
        logic neg;
    } fp_class_t;

    // Base semantics encoded in mode[2:0]
    typedef enum logic [2:0] {
        BASE_IEEE = 3'd0,
        BASE_JAVA = 3'd1,
        BASE_CMAC = 3'd2,
        BASE_CPP  = 3'd3,
        BASE_FORT = 3'd4
    } base_t;

    // Which value leaves the block
    typedef enum logic [1:0] {
        PICK_A  = 2'd0,
        PICK_B  = 2'd1,
        PICK_QA = 2'd2,
        PICK_QB = 2'd3
    } pick_t;

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
    import fmm_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int EXP_W = 8
) (
    input  logic [WIDTH-1:0] val,
    output fp_class_t        cls
);
    localparam int FRAC_W = WIDTH - EXP_W - 1;

    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones  = &val[WIDTH-2:FRAC_W];
        frac_nz   = |val[FRAC_W-1:0];
        cls.nan   = exp_ones & frac_nz;
        cls.snan  = exp_ones & frac_nz & ~val[FRAC_W-1];
        cls.zero  = ~|val[WIDTH-2:0];
        cls.neg   = val[WIDTH-1];
    end
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             a_lt_b,
    output logic             mag_lt,
    output logic             mag_eq
);
    logic [WIDTH-2:0] mag_a;
    logic [WIDTH-2:0] mag_b;
    logic             both_zero;

    always_comb begin
        mag_a     = a[WIDTH-2:0];
        mag_b     = b[WIDTH-2:0];
        mag_lt    = mag_a < mag_b;
        mag_eq    = mag_a == mag_b;
        both_zero = (mag_a == '0) && (mag_b == '0);
        if (both_zero) begin
            a_lt_b = 1'b0;
        end else if (a[WIDTH-1] != b[WIDTH-1]) begin
            a_lt_b = a[WIDTH-1];
        end else if (a[WIDTH-1]) begin
            a_lt_b = mag_a > mag_b;
        end else begin
            a_lt_b = mag_lt;
        end
    end
endmodule

// File: rtl/fmm_resolve.sv
module fmm_resolve
    import fmm_pkg::*;
(
    input  fp_class_t cls_a,
    input  fp_class_t cls_b,
    input  base_t     base,
    input  logic      is_max,
    input  logic      mag_mode,
    input  logic      a_lt_b,
    input  logic      mag_lt,
    input  logic      mag_eq,
    output pick_t     pick,
    output logic      inv
);
    logic any_nan;
    logic any_snan;
    logic both_zero;
    pick_t ordered;
    pick_t zero_sel;

    always_comb begin
        any_nan   = cls_a.nan | cls_b.nan;
        any_snan  = cls_a.snan | cls_b.snan;
        both_zero = cls_a.zero & cls_b.zero;

        // Plain numeric choice
        if (is_max) ordered = a_lt_b ? PICK_B : PICK_A;
        else        ordered = a_lt_b ? PICK_A : PICK_B;

        // Sign-aware choice among two zeros (also covers equal values)
        if (is_max) zero_sel = cls_a.neg ? PICK_B : PICK_A;
        else        zero_sel = cls_a.neg ? PICK_A : PICK_B;

        pick = PICK_A;
        inv  = any_snan;

        if (base == BASE_IEEE) begin
            if (any_snan) begin
                pick = cls_a.snan ? PICK_QA : PICK_QB;
            end else if (cls_a.nan && cls_b.nan) begin
                pick = PICK_QA;
            end else if (cls_a.nan) begin
                pick = PICK_B;
            end else if (cls_b.nan) begin
                pick = PICK_A;
            end else if (mag_mode && !mag_eq) begin
                if (is_max) pick = mag_lt ? PICK_B : PICK_A;
                else        pick = mag_lt ? PICK_A : PICK_B;
            end else if (both_zero) begin
                pick = zero_sel;
            end else begin
                pick = ordered;
            end
        end else if (any_nan) begin
            unique case (base)
                BASE_JAVA: begin
                    if (cls_a.snan)      pick = PICK_QA;
                    else if (cls_b.snan) pick = PICK_QB;
                    else                 pick = cls_a.nan ? PICK_A : PICK_B;
                end
                BASE_FORT: pick = cls_b.nan ? PICK_A : PICK_B;
                BASE_CMAC: begin
                    pick = PICK_B;
                    inv  = 1'b1;
                end
                BASE_CPP: begin
                    pick = PICK_A;
                    inv  = 1'b1;
                end
                default: pick = PICK_A;
            endcase
        end else if (both_zero) begin
            unique case (base)
                BASE_CMAC: pick = PICK_B;
                BASE_CPP:  pick = PICK_A;
                default:   pick = zero_sel;
            endcase
        end else begin
            pick = ordered;
        end
    end
endmodule

// File: rtl/fp_minmax_sel.sv
module fp_minmax_sel
    import fmm_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int EXP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             want_max,
    input  logic [3:0]       mode,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             invalid
);
    localparam int FRAC_W = WIDTH - EXP_W - 1;
    localparam logic [WIDTH-1:0] QUIET_BIT = WIDTH'(1) << (FRAC_W - 1);

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] res;
        logic             inv;
    } state_t;

    state_t st_d;
    state_t st_q;

    base_t base;
    logic  strip_sign;
    logic  a_lt_b;
    logic  mag_lt;
    logic  mag_eq;
    pick_t pick;
    logic  pick_inv;

    logic [WIDTH-1:0] opnd [2];
    fp_class_t        cls  [2];

    always_comb begin
        if (mode[2:0] > 3'(BASE_FORT)) base = BASE_IEEE;
        else                           base = base_t'(mode[2:0]);
        strip_sign = mode[3] && (base != BASE_IEEE);
    end

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        logic [WIDTH-1:0] raw;
        assign raw     = (g == 0) ? op_a : op_b;
        assign opnd[g] = strip_sign ? {1'b0, raw[WIDTH-2:0]} : raw;

        fmm_classify #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_cls (
            .val (opnd[g]),
            .cls (cls[g])
        );
    end

    fmm_order #(.WIDTH(WIDTH)) u_ord (
        .a      (opnd[0]),
        .b      (opnd[1]),
        .a_lt_b (a_lt_b),
        .mag_lt (mag_lt),
        .mag_eq (mag_eq)
    );

    fmm_resolve u_res (
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .base     (base),
        .is_max   (want_max),
        .mag_mode (mode[3]),
        .a_lt_b   (a_lt_b),
        .mag_lt   (mag_lt),
        .mag_eq   (mag_eq),
        .pick     (pick),
        .inv      (pick_inv)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.inv   = 1'b0;
        if (in_valid) begin
            st_d.inv = pick_inv;
            unique case (pick)
                PICK_A:  st_d.res = opnd[0];
                PICK_B:  st_d.res = opnd[1];
                PICK_QA: st_d.res = opnd[0] | QUIET_BIT;
                PICK_QB: st_d.res = opnd[1] | QUIET_BIT;
                default: st_d.res = opnd[0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.res;
    assign invalid   = st_q.inv;
endmodule

// File: rtl/fmm_checker.sv
module fmm_checker #(
    parameter int WIDTH = 32,
    parameter int EXP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             want_max,
    input logic [3:0]       mode,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic             invalid
);
    localparam int FRAC_W = WIDTH - EXP_W - 1;

    function automatic logic is_nan(input logic [WIDTH-1:0] x);
        return (&x[WIDTH-2:FRAC_W]) && (|x[FRAC_W-1:0]);
    endfunction

    function automatic logic is_snan(input logic [WIDTH-1:0] x);
        return is_nan(x) && !x[FRAC_W-1];
    endfunction

    logic unused_sel;
    assign unused_sel = want_max;

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_idle_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!invalid && $stable(result)));

    assert_cxx_nan_inv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode[2:0] == 3'd2 || mode[2:0] == 3'd3) &&
         (is_nan(op_a) || is_nan(op_b))) |=> invalid);

    assert_snan_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (is_snan(op_a) || is_snan(op_b))) |=> invalid);

    assert_pick_operand_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode[3] && !is_nan(op_a) && !is_nan(op_b)) |=>
        (result == $past(op_a) || result == $past(op_b)));

    assert_mag_sign_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[3] && mode[2:0] >= 3'd1 && mode[2:0] <= 3'd4) |=>
        !result[WIDTH-1]);
endmodule

bind fp_minmax_sel fmm_checker #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .want_max  (want_max),
    .mode      (mode),
    .out_valid (out_valid),
    .result    (result),
    .invalid   (invalid)
);

// File: tb/sim_fp_minmax_sel.sv
`timescale 1ns/1ps
module sim_fp_minmax_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        want_max = 1'b0;
    logic [3:0]  mode = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        invalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fp_minmax_sel u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .want_max(want_max), .mode(mode), .out_valid(out_valid),
        .result(result), .invalid(invalid)
    );

    localparam int NV = 14;
    localparam logic [31:0] POOL [NV] = '{
        32'h00000000, 32'h80000000, 32'h3F800000, 32'hBF800000,
        32'h40000000, 32'hC0600000, 32'h7F800000, 32'hFF800000,
        32'h7FC00000, 32'hFFC12345, 32'h7F800001, 32'hFFA00000,
        32'h00000001, 32'h3F800001
    };
    localparam int NM = 12;
    localparam logic [3:0] MODES [NM] = '{
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5,
        4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13
    };

    function automatic bit f_nan(input logic [31:0] x);
        return x[30:23] == 8'hFF && x[22:0] != 0;
    endfunction
    function automatic bit f_snan(input logic [31:0] x);
        return f_nan(x) && !x[22];
    endfunction
    function automatic bit f_zero(input logic [31:0] x);
        return x[30:0] == 0;
    endfunction
    function automatic longint f_key(input logic [31:0] x);
        longint m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction
    function automatic logic [31:0] f_q(input logic [31:0] x);
        return x | 32'h0040_0000;
    endfunction

    // Expected {invalid, result}
    function automatic logic [32:0] model(input logic [31:0] a_in, input logic [31:0] b_in,
                                          input bit mx, input logic [3:0] md);
        logic [31:0] a = a_in;
        logic [31:0] b = b_in;
        logic [31:0] r;
        bit inv;
        int base = (md[2:0] > 3'd4) ? 0 : int'(md[2:0]);
        bit mag = md[3];
        if (base != 0 && mag) begin
            a[31] = 1'b0;
            b[31] = 1'b0;
        end
        inv = f_snan(a) || f_snan(b);
        if (base == 0) begin
            if (inv)                     r = f_snan(a) ? f_q(a) : f_q(b);
            else if (f_nan(a) && f_nan(b)) r = f_q(a);
            else if (f_nan(a))           r = b;
            else if (f_nan(b))           r = a;
            else if (mag && a[30:0] != b[30:0])
                r = ((a[30:0] < b[30:0]) ^ mx) ? a : b;
            else if (f_key(a) == f_key(b))
                r = (a[31] ^ mx) ? a : b;
            else
                r = ((f_key(a) < f_key(b)) ^ mx) ? a : b;
        end else if (f_nan(a) || f_nan(b)) begin
            case (base)
                1: r = f_snan(a) ? f_q(a) : f_snan(b) ? f_q(b) : f_nan(a) ? a : b;
                4: r = f_nan(b) ? a : b;
                2: begin r = b; inv = 1; end
                default: begin r = a; inv = 1; end
            endcase
        end else if (f_zero(a) && f_zero(b)) begin
            case (base)
                2: r = b;
                3: r = a;
                default: r = mx ? (a[31] ? b : a) : (a[31] ? a : b);
            endcase
        end else begin
            r = ((f_key(a) < f_key(b)) ^ mx) ? a : b;
        end
        return {inv, r};
    endfunction

    function automatic string tag_of(input logic [31:0] a, input logic [31:0] b,
                                     input bit mx, input logic [3:0] md);
        int base = (md[2:0] > 3'd4) ? 0 : int'(md[2:0]);
        if (md[2:0] > 3'd4) return "R2";
        if (f_nan(a) || f_nan(b)) begin
            case (base)
                0: return "R4";
                1: return "R6";
                4: return "R7";
                default: return "R8";
            endcase
        end
        if (base == 0) return md[3] ? "R13" : "R5";
        if (md[3]) return "R12";
        if (f_zero(a) && f_zero(b)) return mx ? "R11" : "R10";
        return "R3";
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa, pb;
        logic [3:0]  pm;
        bit          px;
        bit          have_prev;
        logic [32:0] e;
        logic [31:0] last_res;

        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", 32'(out_valid), 32'd0);

        have_prev = 0;
        pa = '0; pb = '0; pm = '0; px = 0;
        for (int mi = 0; mi < NM; mi++) begin
            for (int s = 0; s < 2; s++) begin
                for (int i = 0; i < NV; i++) begin
                    for (int j = 0; j < NV; j++) begin
                        @(negedge clk);
                        if (have_prev) begin
                            e = model(pa, pb, px, pm);
                            check("R1", "out_valid", 32'(out_valid), 32'd1);
                            check(tag_of(pa, pb, px, pm), "result", result, e[31:0]);
                            check("R9", "invalid", 32'(invalid), 32'(e[32]));
                        end
                        pa = POOL[i]; pb = POOL[j]; pm = MODES[mi]; px = bit'(s);
                        op_a = pa; op_b = pb; mode = pm; want_max = px;
                        in_valid = 1'b1;
                        have_prev = 1;
                    end
                end
            end
        end
        @(negedge clk);
        e = model(pa, pb, px, pm);
        check(tag_of(pa, pb, px, pm), "result last", result, e[31:0]);
        check("R9", "invalid last", 32'(invalid), 32'(e[32]));
        last_res = result;

        // Idle: new operand values present but not valid
        in_valid = 1'b0;
        op_a = 32'h3F800000;
        op_b = 32'h7F800001;
        mode = 4'd2;
        @(negedge clk);
        check("R14", "idle out_valid", 32'(out_valid), 32'd0);
        check("R14", "idle invalid", 32'(invalid), 32'd0);
        check("R14", "idle result hold", result, last_res);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule